// File: doc/BRIEF.md
# Five-Phase Multi-Cycle Processor Core

This block is a small processor that does not overlap instructions. Each instruction goes through five phases, one clock cycle each. In order they are fetch, decode with operand read, execute, memory, and register write-back. A new instruction starts only after the previous one has finished its write-back. Every instruction therefore takes exactly five cycles.

The core reads a word-addressed instruction store through a 5-bit program counter. It holds 32 eight-bit registers. It drives a write-only data memory port. Three operations are supported:

- register add
- store with base plus offset
- move of a 5-bit immediate

Any other opcode does nothing for its five cycles. A one-cycle pulse marks each write-back cycle.

The sequencer has five named states: `PH_IF` (0), `PH_ID` (1), `PH_EX` (2), `PH_MEM` (3) and `PH_WB` (4). The transitions are:

- `PH_IF`→`PH_ID` when the fetch completes.
- `PH_ID`→`PH_EX` after the operands are latched.
- `PH_EX`→`PH_MEM` after the result is latched.
- `PH_MEM`→`PH_WB` after the memory write slot.
- `PH_WB`→`PH_IF` when the instruction retires.
- Any state → `PH_IF` on reset.

Top module: `mc5_core`

## Requirements
- R1: After reset the phase output steps 0,1,2,3,4,0,... one value per clock, with the encoding fetch=0, decode=1, execute=2, memory=3, write-back=4.
- R2: An instruction word is 21 bits. The opcode is in bits 20:15, field A in bits 14:10, field B in bits 9:5 and field C in bits 4:0.
- R3: Opcode 000111 (add) sets register A to (register B + register C) mod 256 at the end of write-back. The next instruction sees the new value.
- R4: Opcode 111001 (store) drives `dmem_we` high for the memory cycle only. In that cycle `dmem_addr` = (register B + C) mod 256 and `dmem_wdata` = register A. No register changes.
- R5: Opcode 000001 (move immediate) sets register A to C, zero-extended, at the end of write-back. Field B is ignored.
- R6: Any other opcode performs no data memory write and changes no register. It still takes five cycles.
- R7: `imem_addr` shows the program counter. The word is fetched in the fetch cycle. The counter increments at the end of fetch and wraps from 31 to 0.
- R8: `dmem_we` is low in every cycle other than the memory cycle of a store.
- R9: `retire_o` is high exactly during each write-back cycle.
- R10: A synchronous reset returns the phase to fetch, sets the program counter to 0, clears all 32 registers and holds `dmem_we` low.
- R11: Operands are read in the decode cycle from the registers named by the fields. A destination that is also a source uses its old value, so add r2,r2,r2 doubles r2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 5 | Instruction word address (program counter) |
| imem_rdata | input | 21 | Instruction word at `imem_addr`, combinational |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_addr | output | 8 | Data memory write address |
| dmem_wdata | output | 8 | Data memory write data |
| phase_o | output | 3 | Current phase code |
| retire_o | output | 1 | High during the write-back cycle |

## Verification
The hardest condition to reach from the ports is a reset that arrives in the middle of an instruction, after registers have been written. The bench must then show that the register file really was cleared.

The program first runs past the point where r9 is loaded, and lets the counter wrap so that the word at address 0 stores r9 again. Reset is then asserted during an execute phase. The store at address 0 must write zero, which shows the cleared state.

Sum wrap-around, an offset that wraps the address, and a register used as both source and destination are all placed directly in the program.

// File: rtl/mc5_pkg.sv
package mc5_pkg;

    localparam int OPC_W = 6;

    typedef enum logic [2:0] {
        PH_IF  = 3'd0,
        PH_ID  = 3'd1,
        PH_EX  = 3'd2,
        PH_MEM = 3'd3,
        PH_WB  = 3'd4
    } phase_e;

    localparam logic [OPC_W-1:0] OPC_ADD   = 6'b000111;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'b111001;
    localparam logic [OPC_W-1:0] OPC_MOVI  = 6'b000001;

    typedef enum logic [1:0] {
        K_NOP   = 2'd0,
        K_ADD   = 2'd1,
        K_STORE = 2'd2,
        K_MOVI  = 2'd3
    } kind_e;

endpackage

// File: rtl/mc5_seq.sv
module mc5_seq
    import mc5_pkg::*;
#(
    parameter int PC_W = 5
) (
    input  logic            clk,
    input  logic            rst,
    output phase_e          phase_o,
    output logic [PC_W-1:0] pc_o,
    output logic            fetch_en,
    output logic            read_en,
    output logic            exec_en,
    output logic            mem_en,
    output logic            wb_en
);

    phase_e          phase_q, phase_d;
    logic [PC_W-1:0] pc_q, pc_d, pc_inc;

    assign pc_inc = pc_q + 1'b1;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IF;
            pc_q    <= '0;
        end else begin
            phase_q <= phase_d;
            pc_q    <= pc_d;
        end
    end

    // next phase and counter
    always_comb begin
        phase_d = PH_IF;
        pc_d    = pc_q;
        unique case (phase_q)
            PH_IF: begin
                phase_d = PH_ID;
                pc_d    = pc_inc;
            end
            PH_ID:   phase_d = PH_EX;
            PH_EX:   phase_d = PH_MEM;
            PH_MEM:  phase_d = PH_WB;
            PH_WB:   phase_d = PH_IF;
            default: phase_d = PH_IF;
        endcase
    end

    // phase enables
    always_comb begin
        fetch_en = 1'b0;
        read_en  = 1'b0;
        exec_en  = 1'b0;
        mem_en   = 1'b0;
        wb_en    = 1'b0;
        unique case (phase_q)
            PH_IF:   fetch_en = 1'b1;
            PH_ID:   read_en  = 1'b1;
            PH_EX:   exec_en  = 1'b1;
            PH_MEM:  mem_en   = 1'b1;
            PH_WB:   wb_en    = 1'b1;
            default: ;
        endcase
    end

    assign phase_o = phase_q;
    assign pc_o    = pc_q;

    // R1
    wb_wraps_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_WB) |=> (phase_q == PH_IF));
    // R1
    if_leads_id_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IF) |=> (phase_q == PH_ID));
    // R7
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IF) |=> (pc_q == $past(pc_inc)));
    // R7
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IF) |=> $stable(pc_q));

endmodule

// File: rtl/mc5_decode.sv
module mc5_decode
    import mc5_pkg::*;
#(
    parameter  int FLD_W   = 5,
    localparam int INSTR_W = OPC_W + 3 * FLD_W
) (
    input  logic [INSTR_W-1:0] ir,
    output kind_e              kind,
    output logic [FLD_W-1:0]   fld_a,
    output logic [FLD_W-1:0]   fld_b,
    output logic [FLD_W-1:0]   fld_c
);

    logic [OPC_W-1:0] opc;

    assign opc   = ir[INSTR_W-1 -: OPC_W];
    assign fld_a = ir[3*FLD_W-1 -: FLD_W];
    assign fld_b = ir[2*FLD_W-1 -: FLD_W];
    assign fld_c = ir[FLD_W-1:0];

    always_comb begin
        unique case (opc)
            OPC_ADD:   kind = K_ADD;
            OPC_STORE: kind = K_STORE;
            OPC_MOVI:  kind = K_MOVI;
            default:   kind = K_NOP;
        endcase
    end

endmodule

// File: rtl/mc5_regfile.sv
module mc5_regfile #(
    parameter  int AW    = 5,
    parameter  int DW    = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a,
    output logic [DW-1:0] rd_a,
    input  logic [AW-1:0] ra_b,
    output logic [DW-1:0] rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wa] <= wd;
        end
    end

    assign rd_a = mem[ra_a];
    assign rd_b = mem[ra_b];

endmodule

// File: rtl/mc5_alu.sv
module mc5_alu
    import mc5_pkg::*;
#(
    parameter int DW    = 8,
    parameter int IMM_W = 5
) (
    input  kind_e            kind,
    input  logic [DW-1:0]    opa,
    input  logic [DW-1:0]    opb,
    input  logic [IMM_W-1:0] imm,
    output logic [DW-1:0]    result
);

    logic [DW-1:0] imm_ext;

    assign imm_ext = DW'(imm);

    always_comb begin
        unique case (kind)
            K_ADD:   result = opa + opb;
            K_STORE: result = opa + imm_ext;
            K_MOVI:  result = imm_ext;
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/mc5_core.sv
module mc5_core
    import mc5_pkg::*;
#(
    parameter  int PC_W    = 5,
    parameter  int REG_AW  = 5,
    parameter  int DATA_W  = 8,
    localparam int INSTR_W = OPC_W + 3 * REG_AW
) (
    input  logic               clk,
    input  logic               rst,
    output logic [PC_W-1:0]    imem_addr,
    input  logic [INSTR_W-1:0] imem_rdata,
    output logic               dmem_we,
    output logic [DATA_W-1:0]  dmem_addr,
    output logic [DATA_W-1:0]  dmem_wdata,
    output logic [2:0]         phase_o,
    output logic               retire_o
);

    phase_e             phase;
    logic [PC_W-1:0]    pc;
    logic               fetch_en, read_en, exec_en, mem_en, wb_en;
    logic [INSTR_W-1:0] ir_q;
    kind_e              kind;
    logic [REG_AW-1:0]  fa, fb, fc;
    logic [DATA_W-1:0]  rd_a, rd_b, alu_out;
    logic [DATA_W-1:0]  opa_q, opb_q, res_q;
    logic [REG_AW-1:0]  rb_sel;
    logic               rf_we;

    mc5_seq #(.PC_W(PC_W)) seq_i (
        .clk(clk), .rst(rst), .phase_o(phase), .pc_o(pc),
        .fetch_en(fetch_en), .read_en(read_en), .exec_en(exec_en),
        .mem_en(mem_en), .wb_en(wb_en)
    );

    mc5_decode #(.FLD_W(REG_AW)) dec_i (
        .ir(ir_q), .kind(kind), .fld_a(fa), .fld_b(fb), .fld_c(fc)
    );

    // a store reads its data register through the second port
    assign rb_sel = (kind == K_STORE) ? fa : fc;

    mc5_regfile #(.AW(REG_AW), .DW(DATA_W)) rf_i (
        .clk(clk), .rst(rst),
        .ra_a(fb), .rd_a(rd_a),
        .ra_b(rb_sel), .rd_b(rd_b),
        .we(rf_we), .wa(fa), .wd(res_q)
    );

    mc5_alu #(.DW(DATA_W), .IMM_W(REG_AW)) alu_i (
        .kind(kind), .opa(opa_q), .opb(opb_q), .imm(fc), .result(alu_out)
    );

    // datapath latches, one per phase
    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q  <= '0;
            opa_q <= '0;
            opb_q <= '0;
            res_q <= '0;
        end else begin
            if (fetch_en) ir_q <= imem_rdata;
            if (read_en) begin
                opa_q <= rd_a;
                opb_q <= rd_b;
            end
            if (exec_en) res_q <= alu_out;
        end
    end

    assign rf_we      = wb_en && (kind == K_ADD || kind == K_MOVI);
    assign imem_addr  = pc;
    assign dmem_we    = mem_en && (kind == K_STORE);
    assign dmem_addr  = res_q;
    assign dmem_wdata = opb_q;
    assign phase_o    = phase;
    assign retire_o   = wb_en;

    // R8
    dmem_we_phase_chk: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (phase == PH_MEM));
    // R9
    retire_single_chk: assert property (@(posedge clk) disable iff (rst)
        retire_o |=> !retire_o);
    // R3
    rf_we_in_wb_chk: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> retire_o);
    // R4
    store_no_rf_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == K_STORE) |-> !rf_we);
    // R11
    opnd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EX) |=> $stable(opa_q) && $stable(opb_q));

endmodule

// File: tb/mc5_core_tb.sv
module mc5_core_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  imem_addr;
    logic [20:0] imem_rdata;
    logic        dmem_we;
    logic [7:0]  dmem_addr, dmem_wdata;
    logic [2:0]  phase_o;
    logic        retire_o;

    logic [20:0] prog [32];
    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    assign imem_rdata = prog[imem_addr];

    mc5_core dut_i (
        .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .phase_o(phase_o), .retire_o(retire_o)
    );

    // R2: opcode [20:15], A [14:10], B [9:5], C [4:0]
    function automatic logic [20:0] enc(input int op, input int a, input int b, input int c);
        return {6'(op), 5'(a), 5'(b), 5'(c)};
    endfunction

    // reference state
    int m_ph;
    int m_pc;
    int m_reg [32];
    logic [20:0] m_ir;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ph = 0; m_pc = 0; m_ir = '0;
        for (int i = 0; i < 32; i++) m_reg[i] = 0;
    endtask

    task automatic compare();
        int op, a, b, c;
        bit we;
        op = int'(m_ir[20:15]); a = int'(m_ir[14:10]);
        b = int'(m_ir[9:5]);    c = int'(m_ir[4:0]);
        we = (m_ph == 3) && (op == 'h39);
        chk("R1", "phase", int'(phase_o), m_ph);
        chk("R7", "imem_addr", int'(imem_addr), m_pc);
        chk("R9", "retire", int'(retire_o), (m_ph == 4) ? 1 : 0);
        if (m_ph == 3 && op != 'h39 && op != 'h07 && op != 'h01)
            chk("R6", "dmem_we", int'(dmem_we), 0);
        else
            chk(we ? "R4" : "R8", "dmem_we", int'(dmem_we), we ? 1 : 0);
        if (we) begin
            chk("R4", "dmem_addr", int'(dmem_addr), (m_reg[b] + c) % 256);
            chk("R4", "dmem_wdata", int'(dmem_wdata), m_reg[a]);
        end
    endtask

    task automatic model_step();
        int op, a, b, c;
        if (m_ph == 0) begin
            m_ir = prog[m_pc];
            m_pc = (m_pc + 1) % 32;
        end
        if (m_ph == 4) begin
            op = int'(m_ir[20:15]); a = int'(m_ir[14:10]);
            b = int'(m_ir[9:5]);    c = int'(m_ir[4:0]);
            if (op == 'h07) m_reg[a] = (m_reg[b] + m_reg[c]) % 256;  // R3
            else if (op == 'h01) m_reg[a] = c;                         // R5
        end
        m_ph = (m_ph + 1) % 5;
    endtask

    initial begin
        prog[0]  = enc('h39, 9, 0, 0);    // store r9 -> 0 after reset (R10)
        prog[1]  = enc('h01, 2, 0, 21);   // mov r2,21
        prog[2]  = enc('h07, 2, 2, 2);    // r2 = 2A, dest also source (R11)
        prog[3]  = enc('h01, 3, 0, 18);   // r3 = 12
        prog[4]  = enc('h07, 1, 2, 3);    // r1 = 3C (R3)
        prog[5]  = enc('h39, 1, 4, 0);    // store r1,0(r4)
        prog[6]  = enc('h07, 5, 1, 1);    // 78
        prog[7]  = enc('h07, 5, 5, 5);    // F0
        prog[8]  = enc('h07, 6, 5, 5);    // E0, sum wraps (R3)
        prog[9]  = enc('h39, 6, 1, 3);    // addr 3F
        prog[10] = enc('h01, 7, 17, 31);  // B field ignored (R5)
        prog[11] = enc('h39, 7, 5, 31);   // address wraps to 0F (R4)
        prog[12] = enc('h3F, 1, 2, 3);    // unknown (R6)
        prog[13] = enc('h00, 1, 1, 1);    // unknown (R6)
        prog[14] = enc('h39, 1, 0, 0);    // r1 still 3C
        prog[15] = enc('h39, 5, 5, 5);    // data reg = base reg
        prog[16] = enc('h01, 9, 0, 7);
        prog[17] = enc('h39, 9, 0, 1);
        prog[18] = enc('h01, 10, 0, 0);
        for (int i = 19; i < 32; i++)
            prog[i] = (i % 2 == 0) ? enc('h07, 11, 11, 2) : enc('h39, 11, 0, i);
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk("R10", "phase", int'(phase_o), 0);
        chk("R10", "imem_addr", int'(imem_addr), 0);
        chk("R10", "dmem_we", int'(dmem_we), 0);
        chk("R10", "retire", int'(retire_o), 0);
        rst = 1'b0;
        model_reset();
        for (int k = 0; k < 200; k++) begin   // 40 instructions, PC wraps (R7)
            compare();
            model_step();
            @(negedge clk);
        end
        while (m_ph != 2) begin
            compare();
            model_step();
            @(negedge clk);
        end
        rst = 1'b1;                            // R10: reset in mid-execute
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        for (int k = 0; k < 125; k++) begin
            compare();
            model_step();
            @(negedge clk);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        wait (cyc > 5000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule